// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers data words between two unrelated clocks. A producer in the write clock domain pushes words when both its clock enable and write enable are high. A consumer in the read clock domain pops words in the same order when its clock enable and read enable are high. The storage is a RAM of 2^ADDR_W words. Each side keeps a binary pointer one bit wider than the address. It publishes that pointer as a registered Gray code, and the other side samples it through a two-flop synchronizer.

Each side holds a small state register that records the fill level. The write side has the states WS_ROOM (below the almost-full level), WS_NEAR (at or above ALMOST_FULL_LVL, below FULL_LVL) and WS_FULL (at or above FULL_LVL). The read side has the states RS_EMPTY (nothing stored), RS_LOW (1 to ALMOST_EMPTY_LVL words) and RS_FILL (more than ALMOST_EMPTY_LVL words). On every edge of its own clock, each side moves straight to the state that matches the occupancy the next pointers will give. Any state can therefore step to any other in one cycle. The flags are decoded from these states. Because a pointer from the other domain reaches a side late, that side sees occupancy pessimistically. Flags that guard the local side rise at once. They fall only after the other side's progress has crossed over.

The legal parameter ranges are: FULL_LVL from 1 to 2^ADDR_W−1, and ALMOST_FULL_LVL and ALMOST_EMPTY_LVL each from 1 to FULL_LVL−1. The empty level is fixed at zero words. The active-low rst_n clears both pointers, both synchronizers and both state registers. A one-cycle rd_rewind pulse puts only the read pointer back to the start of the buffer, so the words written since reset are read out again. This replay is meaningful only while no more than FULL_LVL words have been written since rst_n.

Top module: `afifo_pf`

## Requirements
- R1: While rst_n is low and after it is released, empty and aempty are 1 and full and afull are 0. Words written before the reset are never read after it.
- R2: A write is taken on a wr_clk edge exactly when wr_ce and wr_en are both 1 and full is 0. Words taken are stored in arrival order.
- R3: A read is taken on a rd_clk edge exactly when rd_ce and rd_en are both 1, empty is 0 and rd_rewind is 0. The word appears on rd_data after that same edge, and rd_data holds its value while no read is taken.
- R4: full is 1 right after the wr_clk edge whose write brings occupancy to FULL_LVL. Writes attempted while full is 1 are discarded.
- R5: afull is 1 whenever write-side occupancy is at least ALMOST_FULL_LVL, including right after the write that reaches it. Once both sides are idle, afull is 0 below that level.
- R6: empty is 1 right after the rd_clk edge of the read that takes the last stored word. While empty is 1, reads change nothing.
- R7: aempty is 1 whenever read-side occupancy is at most ALMOST_EMPTY_LVL. Once both sides are idle, aempty is 0 above that level.
- R8: After the other side moves its pointer, full, afull, empty and aempty reach the value that matches the true occupancy within a few cycles of their own clock.
- R9: A 1 on rd_rewind at a rd_clk edge returns the read pointer to the start of the buffer and leaves the write pointer unchanged. A read requested in that cycle is not taken. Later reads return again every word written since rst_n, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Global asynchronous reset, active low; clears pointers and flags |
| wr_clk | input | 1 | Write clock |
| wr_ce | input | 1 | Write clock enable |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Occupancy at or above FULL_LVL (write clock) |
| afull | output | 1 | Occupancy at or above ALMOST_FULL_LVL (write clock) |
| rd_clk | input | 1 | Read clock |
| rd_ce | input | 1 | Read clock enable |
| rd_en | input | 1 | Read enable |
| rd_rewind | input | 1 | Returns the read pointer to the buffer start |
| rd_data | output | DATA_W | Word from the last read taken |
| empty | output | 1 | No word stored (read clock) |
| aempty | output | 1 | Occupancy at or below ALMOST_EMPTY_LVL (read clock) |

## Verification
The bench fills the buffer to exactly FULL_LVL and then keeps pushing. A design that lets a write through while full would wrap over unread words, and the drain would return the wrong data or more words than were taken. It drains to zero and keeps requesting reads. A late empty flag would hand out stale words, and a pointer that moved while empty would skip data. It steps occupancy across each almost level and checks the flag on both sides of the edge, which catches off-by-one compares. It also rewinds partway through a drain, with a read request in the same cycle. A rewind that moved the write pointer, or that also took the read, would replay the wrong first word or the wrong count.

// File: rtl/afifo_pf_pkg.sv
package afifo_pf_pkg;

    typedef enum logic [1:0] {
        WS_ROOM = 2'd0,
        WS_NEAR = 2'd1,
        WS_FULL = 2'd2
    } wstate_t;

    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_LOW   = 2'd1,
        RS_FILL  = 2'd2
    } rstate_t;

endpackage

// File: rtl/afifo_gray_sync.sv
module afifo_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        bin_out[W-1] = stage2_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2_q[i];
        end
    end

endmodule

// File: rtl/afifo_ram.sv
module afifo_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              rst_n,
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/afifo_wside.sv
module afifo_wside
    import afifo_pf_pkg::*;
#(
    parameter int ADDR_W          = 4,
    parameter int FULL_LVL        = 12,
    parameter int ALMOST_FULL_LVL = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ce,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rptr_sync,
    output logic [ADDR_W:0]   wptr_gray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              full,
    output logic              afull
);

    localparam int PW = ADDR_W + 1;

    wstate_t       state_q;
    wstate_t       state_d;
    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wptr_d;
    logic [PW-1:0] occ_d;
    logic          wr_take;

    assign wr_take   = wr_ce && wr_en && (state_q != WS_FULL);
    assign wptr_d    = wptr_q + PW'(wr_take);
    assign occ_d     = wptr_d - rptr_sync;
    assign mem_we    = wr_take;
    assign mem_waddr = wptr_q[ADDR_W-1:0];

    always_comb begin
        if (occ_d >= PW'(FULL_LVL)) begin
            state_d = WS_FULL;
        end else if (occ_d >= PW'(ALMOST_FULL_LVL)) begin
            state_d = WS_NEAR;
        end else begin
            state_d = WS_ROOM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= WS_ROOM;
            wptr_q    <= '0;
            wptr_gray <= '0;
        end else begin
            state_q   <= state_d;
            wptr_q    <= wptr_d;
            wptr_gray <= wptr_d ^ (wptr_d >> 1);
        end
    end

    always_comb begin
        unique case (state_q)
            WS_ROOM: begin full = 1'b0; afull = 1'b0; end
            WS_NEAR: begin full = 1'b0; afull = 1'b1; end
            WS_FULL: begin full = 1'b1; afull = 1'b1; end
            default: begin full = 1'b1; afull = 1'b1; end
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_ce && wr_en) |=> $stable(wptr_q)); // R4

    AST_WR_VIEW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((wptr_q - rptr_sync) <= PW'(FULL_LVL))); // R2

endmodule

// File: rtl/afifo_rside.sv
module afifo_rside
    import afifo_pf_pkg::*;
#(
    parameter int ADDR_W           = 4,
    parameter int FULL_LVL         = 12,
    parameter int ALMOST_EMPTY_LVL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ce,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic [ADDR_W:0]   wptr_sync,
    output logic [ADDR_W:0]   rptr_gray,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              empty,
    output logic              aempty
);

    localparam int PW = ADDR_W + 1;

    rstate_t       state_q;
    rstate_t       state_d;
    logic [PW-1:0] rptr_q;
    logic [PW-1:0] rptr_d;
    logic [PW-1:0] occ_d;
    logic          rd_take;

    assign rd_take   = rd_ce && rd_en && !rewind && (state_q != RS_EMPTY);
    assign rptr_d    = rewind ? '0 : (rptr_q + PW'(rd_take));
    assign occ_d     = wptr_sync - rptr_d;
    assign mem_re    = rd_take;
    assign mem_raddr = rptr_q[ADDR_W-1:0];

    always_comb begin
        if (occ_d == '0) begin
            state_d = RS_EMPTY;
        end else if (occ_d <= PW'(ALMOST_EMPTY_LVL)) begin
            state_d = RS_LOW;
        end else begin
            state_d = RS_FILL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RS_EMPTY;
            rptr_q    <= '0;
            rptr_gray <= '0;
        end else begin
            state_q   <= state_d;
            rptr_q    <= rptr_d;
            rptr_gray <= rptr_d ^ (rptr_d >> 1);
        end
    end

    always_comb begin
        unique case (state_q)
            RS_EMPTY: begin empty = 1'b1; aempty = 1'b1; end
            RS_LOW:   begin empty = 1'b0; aempty = 1'b1; end
            RS_FILL:  begin empty = 1'b0; aempty = 1'b0; end
            default:  begin empty = 1'b1; aempty = 1'b1; end
        endcase
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !rewind) |=> $stable(rptr_q)); // R6

    AST_REWIND_START: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (rptr_q == '0)); // R9

    AST_RD_VIEW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((wptr_sync - rptr_q) <= PW'(FULL_LVL))); // R3

endmodule

// File: rtl/afifo_pf.sv
module afifo_pf #(
    parameter int DATA_W           = 8,
    parameter int ADDR_W           = 4,
    parameter int FULL_LVL         = 12,
    parameter int ALMOST_FULL_LVL  = 9,
    parameter int ALMOST_EMPTY_LVL = 3
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_ce,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              afull,
    input  logic              rd_clk,
    input  logic              rd_ce,
    input  logic              rd_en,
    input  logic              rd_rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              aempty
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wptr_gray;
    logic [PW-1:0]     rptr_gray;
    logic [PW-1:0]     wptr_in_rd;
    logic [PW-1:0]     rptr_in_wr;
    logic              mem_we;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;

    afifo_wside #(
        .ADDR_W(ADDR_W), .FULL_LVL(FULL_LVL), .ALMOST_FULL_LVL(ALMOST_FULL_LVL)
    ) u_wside (
        .clk(wr_clk), .rst_n(rst_n), .wr_ce(wr_ce), .wr_en(wr_en),
        .rptr_sync(rptr_in_wr), .wptr_gray(wptr_gray),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .full(full), .afull(afull)
    );

    afifo_rside #(
        .ADDR_W(ADDR_W), .FULL_LVL(FULL_LVL), .ALMOST_EMPTY_LVL(ALMOST_EMPTY_LVL)
    ) u_rside (
        .clk(rd_clk), .rst_n(rst_n), .rd_ce(rd_ce), .rd_en(rd_en),
        .rewind(rd_rewind), .wptr_sync(wptr_in_rd), .rptr_gray(rptr_gray),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .empty(empty), .aempty(aempty)
    );

    afifo_gray_sync #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wptr_in_rd)
    );

    afifo_gray_sync #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rptr_in_wr)
    );

    afifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .rst_n(rst_n), .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr),
        .wdata(wr_data), .rclk(rd_clk), .re(mem_re), .raddr(mem_raddr),
        .rdata(rd_data)
    );

    AST_RESET_FLAGS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> aempty); // R7

endmodule

// File: tb/afifo_pf_bench.sv
module afifo_pf_bench;

    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int FL  = 12;
    localparam int AFL = 9;
    localparam int AEL = 3;

    logic          rst_n = 1'b0;
    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_ce = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_ce = 1'b0, rd_en = 1'b0, rd_rewind = 1'b0;
    logic          full, afull, empty, aempty;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] hist[$];
    int ridx = 0;
    bit wr_done = 0;

    afifo_pf #(
        .DATA_W(DW), .ADDR_W(AW), .FULL_LVL(FL),
        .ALMOST_FULL_LVL(AFL), .ALMOST_EMPTY_LVL(AEL)
    ) u_afifo_pf (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_ce(wr_ce), .wr_en(wr_en),
        .wr_data(wr_data), .full(full), .afull(afull), .rd_clk(rd_clk),
        .rd_ce(rd_ce), .rd_en(rd_en), .rd_rewind(rd_rewind),
        .rd_data(rd_data), .empty(empty), .aempty(aempty)
    );

    always #5 wr_clk = ~wr_clk;
    always #8 rd_clk = ~rd_clk;

    function automatic int occ();
        return hist.size() - ridx;
    endfunction

    function automatic logic exp_full(int o);   return o >= FL;  endfunction
    function automatic logic exp_afull(int o);  return o >= AFL; endfunction
    function automatic logic exp_empty(int o);  return o == 0;   endfunction
    function automatic logic exp_aempty(int o); return o <= AEL; endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wr_clk);
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic check_flags(input string tag);
        int o = occ();
        settle();
        chk(full == exp_full(o), {tag, " full"}, full, exp_full(o));
        chk(afull == exp_afull(o), {tag, " afull"}, afull, exp_afull(o));
        chk(empty == exp_empty(o), {tag, " empty"}, empty, exp_empty(o));
        chk(aempty == exp_aempty(o), {tag, " aempty"}, aempty, exp_aempty(o));
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge wr_clk);
        while (full) @(negedge wr_clk);
        wr_ce = 1; wr_en = 1; wr_data = v;
        @(negedge wr_clk);
        wr_ce = 0; wr_en = 0;
        hist.push_back(v);
    endtask

    task automatic try_push_full(input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_ce = 1; wr_en = 1; wr_data = v;
        @(negedge wr_clk);
        wr_ce = 0; wr_en = 0;
    endtask

    task automatic pop(input string tag);
        logic [DW-1:0] e;
        @(negedge rd_clk);
        while (empty) @(negedge rd_clk);
        rd_ce = 1; rd_en = 1;
        e = hist[ridx];
        ridx++;
        @(negedge rd_clk);
        rd_ce = 0; rd_en = 0;
        chk(rd_data == e, tag, rd_data, e);
    endtask

    task automatic do_reset();
        wr_ce = 0; wr_en = 0; rd_ce = 0; rd_en = 0; rd_rewind = 0;
        #3 rst_n = 0;
        #37;
        hist.delete();
        ridx = 0;
        chk(empty && aempty && !full && !afull, "R1 flags during reset",
            {empty, aempty, full, afull}, 4'b1100);
        #3 rst_n = 1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] last;
        void'($urandom(32'd2024));
        do_reset();
        check_flags("R1 after reset");

        // R2 R7: around the almost-empty level
        for (int i = 0; i < AEL; i++) push(8'h10 + 8'(i));
        check_flags("R7 at AE level");
        push(8'h20);
        check_flags("R7 above AE level");

        // R5: around the almost-full level
        while (occ() < AFL - 1) push(8'h30 + 8'(occ()));
        check_flags("R5 below AF level");
        push(8'h40);
        chk(afull == 1'b1, "R5 afull at once", afull, 1);

        // R4: reach full, then writes are discarded
        while (occ() < FL) push(8'h50 + 8'(occ()));
        chk(full == 1'b1, "R4 full at once", full, 1);
        for (int i = 0; i < 3; i++) try_push_full(8'hEE);
        check_flags("R4 while full");

        // R3 R6: drain in order, then empty at once
        while (occ() > 0) pop("R3 drain order");
        chk(empty == 1'b1, "R6 empty at once", empty, 1);
        check_flags("R8 flags after drain");

        // R6: reads while empty change nothing
        last = rd_data;
        @(negedge rd_clk); rd_ce = 1; rd_en = 1;
        repeat (4) @(negedge rd_clk);
        rd_ce = 0; rd_en = 0;
        chk(rd_data == last, "R6 rd_data held while empty", rd_data, last);
        push(8'hA5);
        pop("R6 no skipped word after empty reads");

        // R2: enable without clock enable is ignored
        @(negedge wr_clk); wr_ce = 0; wr_en = 1; wr_data = 8'hBB;
        @(negedge wr_clk); wr_ce = 1; wr_en = 0;
        @(negedge wr_clk); wr_ce = 0;
        check_flags("R2 partial enables ignored");

        // R1: reset discards content
        for (int i = 0; i < 5; i++) push(8'h60 + 8'(i));
        do_reset();
        check_flags("R1 after mid-fill reset");
        push(8'h77);
        pop("R1 first word after reset");

        // R9: rewind replays everything written since reset
        do_reset();
        for (int i = 0; i < 10; i++) push(8'h80 + 8'(i));
        for (int i = 0; i < 4; i++) pop("R9 before rewind");
        @(negedge rd_clk);
        rd_rewind = 1; rd_ce = 1; rd_en = 1;
        @(negedge rd_clk);
        rd_rewind = 0; rd_ce = 0; rd_en = 0;
        ridx = 0;
        check_flags("R9 flags after rewind");
        while (occ() > 0) pop("R9 replay order");
        chk(empty == 1'b1, "R9 empty after replay", empty, 1);

        // random phase, both sides at once (R2 R3 R4 R6)
        do_reset();
        fork
            begin
                for (int c = 0; c < 1500; c++) begin
                    bit ce, en, take;
                    @(negedge wr_clk);
                    ce = ($urandom % 10) < 8;
                    en = ($urandom % 10) < 7;
                    take = ce && en && !full;
                    wr_ce = ce; wr_en = en; wr_data = 8'($urandom);
                    if (take) hist.push_back(wr_data);
                end
                @(negedge wr_clk);
                wr_ce = 0; wr_en = 0;
                wr_done = 1;
            end
            begin
                bit pend = 0;
                logic [DW-1:0] e = '0;
                while (!wr_done || occ() > 0 || pend) begin
                    bit ce, en;
                    @(negedge rd_clk);
                    if (pend) begin
                        chk(rd_data == e, "R3 random read data", rd_data, e);
                        pend = 0;
                    end
                    ce = ($urandom % 10) < 8;
                    en = ($urandom % 10) < 6;
                    rd_ce = ce; rd_en = en;
                    if (ce && en && !empty) begin
                        e = hist[ridx];
                        ridx++;
                        pend = 1;
                    end
                end
                rd_ce = 0; rd_en = 0;
            end
        join
        check_flags("R8 flags after random phase");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule